// File: doc/BRIEF.md
# Prescaled Timer and IO Register Bank

This block is a word-addressed register bank for a small FPGA system. It drives two LEDs and an eight-line control word: four active-low chip selects, plus a display reset, a register-select line, a read strobe and a backlight enable. It also captures two push buttons and eight slide switches through a two-stage synchronizer. Software reaches every register through a simple 32-bit port: one write strobe and a combinational read-data path.

The bank also keeps time. Two free-running up counters advance once per second and one hundred times per second. Their single-cycle enables come from dividers sized by the `CLK_HZ` parameter, which must be a multiple of 100 and at least 200.

A third up counter counts expiries of a 32-bit down counter. That down counter reloads from a software-written reload register. Software can rewrite the reload register, the running prescale value and every counter at any time. A bus write always wins over the counter's own step in that cycle.

Top module: `sysio_regbank`

## Requirements
- R1: The LED register at byte offset 0x000 stores bits [1:0] of a write and drives `led_out` with them. A read returns those two bits with bits [31:2] zero.
- R2: Byte offset 0x008 reads the buttons on bits [1:0], and offset 0x028 reads the switches on bits [7:0]. All other bits read zero. An input change becomes readable after the second rising clock edge that follows it.
- R3: Writes to offsets 0x008 and 0x028 change nothing.
- R4: The seconds counter at 0x010 increments at each active clock edge whose count since reset is a multiple of `CLK_HZ`. The centisecond counter at 0x014 does the same at multiples of `CLK_HZ/100`. Both are otherwise stable.
- R5: The prescale reload register at 0x01C is a full 32-bit read/write register.
- R6: The prescale value at 0x020 decrements by one at each edge while it is non-zero. At an edge where it is zero, it loads the reload register's value instead.
- R7: The cycle counter at 0x018 increments by one at each edge where the prescale value is zero.
- R8: A write to 0x010, 0x014, 0x018 or 0x020 loads the written word at that edge. It replaces any increment, decrement or reload that the counter would make at the same edge.
- R9: The control register at 0x04C stores write bits [7:0] and drives `misc_out` with them, bits [31:8] reading zero. The bit map is: 0 display select (low active), 1 first expansion SPI select (low active), 2 second expansion SPI select (low active), 3 display reset, 4 display register select, 5 display read strobe, 6 backlight, 7 ADC SPI select (low active).
- R10: A read of any offset not listed here returns zero, and a write to such an offset changes no register.
- R11: After reset every register reads zero, except the control register, which reads 0x87 (all chip selects high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| btn_in | input | 2 | Raw push-button levels |
| sw_in | input | 8 | Raw switch levels |
| led_out | output | 2 | LED drive |
| misc_out | output | 8 | Chip-select and display control lines |

## Verification
The bound checker checks several rules at every edge. It checks the step of the prescale down counter, with its decrement and its reload at zero, and the matching increment of the cycle counter. It checks that a written counter takes the written word, that the rate counters hold between enables, that each enable lasts one cycle, and that unmapped and LED reads return zero in the reserved bits. Some behaviour only the bench's scenarios can show. That covers the synchronizer's two-edge delay, the exact phase of the rate enables counted from reset, and writes ignored by input-only and unmapped offsets. It also covers the reset image and a write that collides with a tick or an expiry.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

  localparam int unsigned DW = 32;

  // word indexes (byte offset / 4)
  localparam int unsigned IDX_LED   = 0;
  localparam int unsigned IDX_BTN   = 2;
  localparam int unsigned IDX_SEC   = 4;
  localparam int unsigned IDX_CENTI = 5;
  localparam int unsigned IDX_CYC   = 6;
  localparam int unsigned IDX_PSRLD = 7;
  localparam int unsigned IDX_PSCUR = 8;
  localparam int unsigned IDX_SW    = 10;
  localparam int unsigned IDX_MISC  = 19;

  localparam int unsigned LED_N  = 2;
  localparam int unsigned BTN_N  = 2;
  localparam int unsigned SW_N   = 8;
  localparam int unsigned MISC_N = 8;

  // chip selects (bits 0,1,2,7) idle high
  localparam logic [MISC_N-1:0] MISC_RST = 8'h87;

  typedef struct packed {
    logic led;
    logic misc;
    logic sec;
    logic centi;
    logic cyc;
    logic psrld;
    logic pscur;
  } wr_dec_t;

  function automatic logic [DW-1:0] prescale_next(input logic [DW-1:0] cur,
                                                  input logic [DW-1:0] rld);
    return (cur == '0) ? rld : cur - DW'(1);
  endfunction

  function automatic logic is_mapped(input logic [31:0] idx);
    case (idx)
      IDX_LED, IDX_BTN, IDX_SEC, IDX_CENTI, IDX_CYC,
      IDX_PSRLD, IDX_PSCUR, IDX_SW, IDX_MISC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sysio_sync.sv
module sysio_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_out  <= '0;
    end else begin
      stage1 <= d_in;
      q_out  <= stage1;
    end
  end
endmodule

// File: rtl/sysio_tick_gen.sv
module sysio_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/sysio_upcnt.sv
module sysio_upcnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (ld)  cnt_q <= ld_val;
    else if (inc) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/sysio_prescale.sv
module sysio_prescale
  import sysio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_reload,
  input  logic          ld_cur,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] reload_q,
  output logic [DW-1:0] cur_q,
  output logic          expire
);
  assign expire = (cur_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (ld_reload) reload_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (ld_cur) cur_q <= wdata;
    else             cur_q <= prescale_next(cur_q, reload_q);
  end
endmodule

// File: rtl/sysio_regbank.sv
module sysio_regbank
  import sysio_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [BTN_N-1:0]  btn_in,
  input  logic [SW_N-1:0]   sw_in,
  output logic [LED_N-1:0]  led_out,
  output logic [MISC_N-1:0] misc_out
);
  localparam int unsigned NRATE     = 2;
  localparam int unsigned DIV_SEC   = CLK_HZ;
  localparam int unsigned DIV_CENTI = CLK_HZ / 100;
  localparam int unsigned IN_N      = BTN_N + SW_N;

  // address decode
  logic [31:0] byte_off;
  logic [31:0] widx;
  wr_dec_t     wsel;

  assign byte_off = 32'(bus_addr);
  assign widx     = byte_off >> 2;

  always_comb begin
    wsel       = '0;
    wsel.led   = bus_wr && (widx == IDX_LED);
    wsel.misc  = bus_wr && (widx == IDX_MISC);
    wsel.sec   = bus_wr && (widx == IDX_SEC);
    wsel.centi = bus_wr && (widx == IDX_CENTI);
    wsel.cyc   = bus_wr && (widx == IDX_CYC);
    wsel.psrld = bus_wr && (widx == IDX_PSRLD);
    wsel.pscur = bus_wr && (widx == IDX_PSCUR);
  end

  // named internal events for the checker
  logic          wr_sec, wr_centi, wr_cyc, wr_ps_cur;
  logic          tick_1hz, tick_100hz, ps_expire;
  logic [DW-1:0] sec_cnt, centi_cnt, cyc_cnt, ps_cur, ps_reload;

  assign wr_sec    = wsel.sec;
  assign wr_centi  = wsel.centi;
  assign wr_cyc    = wsel.cyc;
  assign wr_ps_cur = wsel.pscur;

  // output registers
  logic [LED_N-1:0]  led_q;
  logic [MISC_N-1:0] misc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        led_q <= '0;
    else if (wsel.led) led_q <= bus_wdata[LED_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         misc_q <= MISC_RST;
    else if (wsel.misc) misc_q <= bus_wdata[MISC_N-1:0];
  end

  assign led_out  = led_q;
  assign misc_out = misc_q;

  // input capture
  logic [IN_N-1:0] in_sync;

  sysio_sync #(.W(IN_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({sw_in, btn_in}),
    .q_out (in_sync)
  );

  // fixed-rate counters: index 0 seconds, index 1 centiseconds
  logic [NRATE-1:0] rate_tick;
  logic [NRATE-1:0] rate_ld;
  logic [DW-1:0]    rate_cnt [NRATE];

  assign rate_ld = {wsel.centi, wsel.sec};

  for (genvar g = 0; g < NRATE; g++) begin : g_rate
    localparam int unsigned DIV = (g == 0) ? DIV_SEC : DIV_CENTI;

    sysio_tick_gen #(.DIV(DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (rate_tick[g])
    );

    sysio_upcnt #(.W(DW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (rate_ld[g]),
      .ld_val (bus_wdata),
      .inc    (rate_tick[g]),
      .cnt_q  (rate_cnt[g])
    );
  end

  assign tick_1hz   = rate_tick[0];
  assign tick_100hz = rate_tick[1];
  assign sec_cnt    = rate_cnt[0];
  assign centi_cnt  = rate_cnt[1];

  // prescaled cycle counter
  sysio_prescale u_ps (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_reload (wsel.psrld),
    .ld_cur    (wsel.pscur),
    .wdata     (bus_wdata),
    .reload_q  (ps_reload),
    .cur_q     (ps_cur),
    .expire    (ps_expire)
  );

  sysio_upcnt #(.W(DW)) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (wsel.cyc),
    .ld_val (bus_wdata),
    .inc    (ps_expire),
    .cnt_q  (cyc_cnt)
  );

  // read path
  always_comb begin
    case (widx)
      IDX_LED:   bus_rdata = DW'(led_q);
      IDX_BTN:   bus_rdata = DW'(in_sync[BTN_N-1:0]);
      IDX_SW:    bus_rdata = DW'(in_sync[IN_N-1:BTN_N]);
      IDX_SEC:   bus_rdata = sec_cnt;
      IDX_CENTI: bus_rdata = centi_cnt;
      IDX_CYC:   bus_rdata = cyc_cnt;
      IDX_PSRLD: bus_rdata = ps_reload;
      IDX_PSCUR: bus_rdata = ps_cur;
      IDX_MISC:  bus_rdata = DW'(misc_q);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sysio_regbank_chk.sv
module sysio_regbank_chk
  import sysio_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [LED_N-1:0]  led_out,
  input logic              wr_sec,
  input logic              wr_centi,
  input logic              wr_cyc,
  input logic              wr_ps_cur,
  input logic              tick_1hz,
  input logic              tick_100hz,
  input logic [DW-1:0]     sec_cnt,
  input logic [DW-1:0]     centi_cnt,
  input logic [DW-1:0]     cyc_cnt,
  input logic [DW-1:0]     ps_cur,
  input logic [DW-1:0]     ps_reload
);
  logic [31:0] cidx;
  assign cidx = 32'(bus_addr) >> 2;

  assert_led_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cidx == IDX_LED) |-> (bus_rdata == DW'(led_out)));

  assert_sec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sec && !tick_1hz) |=> $stable(sec_cnt));

  assert_centi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_centi && !tick_100hz) |=> $stable(centi_cnt));

  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_100hz |=> !tick_100hz);

  assert_ps_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ps_cur && ps_cur != '0) |=> (ps_cur == $past(ps_cur) - DW'(1)));

  assert_ps_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ps_cur && ps_cur == '0) |=> (ps_cur == $past(ps_reload)));

  assert_cyc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cyc && ps_cur == '0) |=> (cyc_cnt == $past(cyc_cnt) + DW'(1)));

  assert_cyc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cyc && ps_cur != '0) |=> $stable(cyc_cnt));

  assert_cyc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc |=> (cyc_cnt == $past(bus_wdata)));

  assert_ps_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ps_cur |=> (ps_cur == $past(bus_wdata)));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mapped(cidx) |-> (bus_rdata == '0));
endmodule

bind sysio_regbank sysio_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .led_out    (led_out),
  .wr_sec     (wr_sec),
  .wr_centi   (wr_centi),
  .wr_cyc     (wr_cyc),
  .wr_ps_cur  (wr_ps_cur),
  .tick_1hz   (tick_1hz),
  .tick_100hz (tick_100hz),
  .sec_cnt    (sec_cnt),
  .centi_cnt  (centi_cnt),
  .cyc_cnt    (cyc_cnt),
  .ps_cur     (ps_cur),
  .ps_reload  (ps_reload)
);

// File: tb/sysio_regbank_bench.sv
module sysio_regbank_bench;
  localparam int unsigned HZ = 1000;
  localparam int unsigned AW = 12;

  localparam logic [AW-1:0] A_LED = 12'h000, A_BTN = 12'h008, A_SEC = 12'h010,
    A_CENTI = 12'h014, A_CYC = 12'h018, A_PSR = 12'h01C, A_PSC = 12'h020,
    A_SW = 12'h028, A_MISC = 12'h04C, A_GAP = 12'h00C, A_GAP2 = 12'h02C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [1:0]    btn_in = '0;
  logic [7:0]    sw_in = '0;
  logic [1:0]    led_out;
  logic [7:0]    misc_out;

  sysio_regbank #(.CLK_HZ(HZ), .ADDR_W(AW)) u_sysio_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .btn_in(btn_in),
    .sw_in(sw_in), .led_out(led_out), .misc_out(misc_out));

  always #4 clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    int          src;   // 0 read data, 1 LED pins, 2 control pins
    string       req;
  } item_t;

  item_t sbq[$];
  int n_cmp = 0;
  int n_bad = 0;
  int ncyc  = 0;
  bit done  = 1'b0;

  always @(posedge clk) if (rst_n) ncyc++;

  // monitor: samples between edges
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.src)
        1:       act = 32'(led_out);
        2:       act = 32'(misc_out);
        default: act = bus_rdata;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string rq);
    item_t it;
    bus_addr = a;
    it.exp = e; it.src = 0; it.req = rq;
    sbq.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic pin(input int s, input logic [31:0] e, input string rq);
    item_t it;
    it.exp = e; it.src = s; it.req = rq;
    sbq.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  function automatic int ps_val(int p, int r, int n);
    if (n <= p) return p - n;
    return r - ((n - p - 1) % (r + 1));
  endfunction

  function automatic int ps_hits(int p, int r, int n);
    if (n < p + 1) return 0;
    return (n - p - 1) / (r + 1) + 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset image
    rd(A_LED, 32'h0, "R11 led");
    rd(A_MISC, 32'h87, "R11 misc");
    pin(2, 32'h87, "R11 misc pins");
    rd(A_PSR, 32'h0, "R11 reload");
    rd(A_PSC, 32'h0, "R11 prescale");
    rd(A_BTN, 32'h0, "R11 buttons");
    // R7 with reload zero: expiry every edge
    rd(A_CYC, 32'(ncyc), "R7 cycle at reload zero");
    rd(A_CENTI, 32'(ncyc / 10), "R4 centi from reset");

    // R1 LED
    wr(A_LED, 32'hFFFF_FFFD);
    rd(A_LED, 32'h1, "R1 led read");
    pin(1, 32'h1, "R1 led pins");
    wr(A_LED, 32'h0000_000A);
    rd(A_LED, 32'h2, "R1 led read 2");

    // R9 control word
    wr(A_MISC, 32'h0000_0F5A);
    rd(A_MISC, 32'h5A, "R9 misc read");
    pin(2, 32'h5A, "R9 misc pins");

    // R10 unmapped
    wr(A_GAP, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(A_GAP, 32'h0, "R10 gap read");
    rd(A_GAP2, 32'h0, "R10 gap2 read");
    rd(A_LED, 32'h2, "R10 led untouched");
    pin(2, 32'h5A, "R10 misc untouched");

    // R2 synchronizer delay
    btn_in = 2'b10; sw_in = 8'hA5;
    rd(A_BTN, 32'h0, "R2 btn at 0 edges");
    rd(A_BTN, 32'h0, "R2 btn at 1 edge");
    rd(A_BTN, 32'h2, "R2 btn at 2 edges");
    rd(A_SW, 32'hA5, "R2 switches");

    // R3 writes to inputs ignored
    wr(A_BTN, 32'h1);
    wr(A_SW, 32'h0);
    rd(A_BTN, 32'h2, "R3 btn write ignored");
    rd(A_SW, 32'hA5, "R3 sw write ignored");

    // R5, R6, R7: reload 4, start value 6
    wr(A_PSR, 32'h4);
    rd(A_PSR, 32'h4, "R5 reload read");
    wr(A_PSR, 32'hDEAD_BEEF);
    rd(A_PSR, 32'hDEAD_BEEF, "R5 full width");
    wr(A_PSR, 32'h4);
    wr(A_PSC, 32'd6);
    w = ncyc;
    wr(A_CYC, 32'd1000);
    for (int k = 0; k < 8; k++) begin
      rd(A_PSC, 32'(ps_val(6, 4, ncyc - w)), "R6 prescale sequence");
      rd(A_CYC, 32'(1000 + ps_hits(6, 4, ncyc - w)), "R7 cycle count");
    end

    // R8: cycle write collides with expiry, start value 0 reload 2
    wr(A_PSR, 32'h2);
    wr(A_PSC, 32'd0);
    w = ncyc;
    wr(A_CYC, 32'd50);
    rd(A_CYC, 32'd50, "R8 cycle write beats expiry");
    for (int k = 0; k < 6; k++) begin
      rd(A_PSC, 32'(ps_val(0, 2, ncyc - w)), "R6 reload at zero");
      rd(A_CYC, 32'(50 + ps_hits(0, 2, ncyc - w) - 1), "R7 cycle after collision");
    end

    // R4 seconds from reset
    while (ncyc < 1003) begin @(posedge clk); #1; end
    rd(A_SEC, 32'(ncyc / 1000), "R4 seconds from reset");

    // R8: centi write on its tick edge
    while (((ncyc + 1) % 10) != 0) begin @(posedge clk); #1; end
    wr(A_CENTI, 32'd500);
    w = ncyc;
    rd(A_CENTI, 32'd500, "R8 centi write beats tick");
    for (int k = 0; k < 12; k++)
      rd(A_CENTI, 32'(500 + ncyc / 10 - w / 10), "R4 centi rate");

    // R8 + R4: seconds write then cross a boundary
    wr(A_SEC, 32'd7);
    w = ncyc;
    rd(A_SEC, 32'd7, "R8 seconds load");
    while (ncyc < 2002) begin @(posedge clk); #1; end
    rd(A_SEC, 32'(7 + ncyc / 1000 - w / 1000), "R4 seconds rate");

    done = 1'b1;
    @(negedge clk);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule